// File: doc/BRIEF.md
# Serial Timekeeping Register Port

This block moves the state of a timekeeper, eight BCD-coded bytes, across a single data line one bit per bus cycle. It sits beside a memory array: once an external detector reports a successful unlock (a one-clock `unlock` pulse), the block opens a transfer window of exactly 64 counted bus cycles, and it raises `mem_block` for that whole window so that the memory ignores those cycles.

Each counted cycle (a `cyc_stb` pulse with `ce` high) handles one bit. A cycle with `we` high captures `dq0_i` into the current bit position. A cycle with `we` low is a read cycle, and the current bit is presented on `dq0_o`. The position walks from register 0 to register 7, and within each register from the least significant bit to the most significant. When the window opens, the parallel `live_regs` input is copied into a shadow, so every read sees one consistent snapshot. Written bits are collected in a staging byte. A byte is handed to the external counter through `wr_stb`/`wr_idx`/`wr_data` only when all eight of its cycles were writes.

All inputs are active-high and synchronous to `clk`. `rst` is a synchronous, active-high reset.

Top module: `serial_tkreg_port`

## Requirements
- R1: After reset the window is closed (`mem_block`=0), `dq0_oe`=0 and `wr_stb`=0.
- R2: An `unlock` pulse while the window is closed opens it (`mem_block`=1 from the next clock) at bit position 0. An `unlock` pulse while the window is open is ignored and does not move the position.
- R3: The window closes on the clock edge that ends the 64th counted cycle (`cyc_stb`=1 and `ce`=1). A counted cycle is a read or a write.
- R4: Position k addresses register k/8, bit k%8. During a read cycle at position k, `dq0_o` carries that bit of the snapshot.
- R5: `live_regs` (register r in bits [8r+7:8r]) is copied into the snapshot on the clock edge that opens the window. Later changes to `live_regs` are not seen by reads in that window.
- R6: `dq0_oe` is 1 exactly when the window is open and `ce`=1, `oe`=1 and `we`=0. It is 0 during write cycles and outside the window.
- R7: When the eighth bit of a register is written, and all eight cycles of that register were writes, `wr_stb` is 1 for the single clock after that cycle's edge. `wr_idx` then gives the register number and `wr_data` the byte, with the first-written bit in bit 0.
- R8: A register whose eight cycles include any read cycle produces no `wr_stb`.
- R9: Bus cycles with `ce`=0 neither advance the position nor change the staged bits.
- R10: Outside the window, bus cycles have no effect: `dq0_oe` stays 0, `wr_stb` stays 0 and `mem_block` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock | input | 1 | One-clock pulse from the pattern detector: open the window |
| cyc_stb | input | 1 | One-clock pulse marking the end of a bus cycle |
| ce | input | 1 | Chip enable of the cycle, active high |
| oe | input | 1 | Output enable of the cycle, active high |
| we | input | 1 | Write enable of the cycle, active high |
| dq0_i | input | 1 | Data line 0, input side |
| live_regs | input | 64 | Current counter registers, register r at [8r+7:8r] |
| dq0_o | output | 1 | Data line 0, output side (current snapshot bit) |
| dq0_oe | output | 1 | Drive enable for data line 0 |
| mem_block | output | 1 | Window open; memory access inhibited |
| wr_stb | output | 1 | One-clock commit strobe for a fully written register |
| wr_idx | output | 3 | Register number being committed |
| wr_data | output | 8 | Byte being committed |

## Verification
The hardest states to reach from the ports are the partially written register and the counter value that changes in the middle of a read-out. Both are invisible unless the bench sets them up on purpose. The bench changes `live_regs` halfway through a 64-bit read sweep and checks every bit against the values captured at unlock. It also spends one window mixing reads into the first two registers and writing the rest, then checks that only the fully written registers strobe. Cycles with `ce` low and a second `unlock` pulse are inserted inside open windows. These show that the bit order stays intact after such cycles.

// File: rtl/tkp_pkg.sv
package tkp_pkg;

    localparam int unsigned DEF_NREG = 8;
    localparam int unsigned DEF_RW   = 8;

    typedef enum logic [1:0] {
        CK_NONE  = 2'd0,
        CK_READ  = 2'd1,
        CK_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic stb;
        logic sel;
        logic rd_en;
        logic wr_en;
        logic din;
    } bus_cyc_t;

    function automatic cyc_kind_e classify(input bus_cyc_t c);
        if (!c.stb || !c.sel) begin
            return CK_NONE;
        end else if (c.wr_en) begin
            return CK_WRITE;
        end
        return CK_READ;
    endfunction

    function automatic int unsigned reg_of(input int unsigned p, input int unsigned rw);
        return p / rw;
    endfunction

    function automatic int unsigned bit_of(input int unsigned p, input int unsigned rw);
        return p % rw;
    endfunction

endpackage

// File: rtl/tkp_window.sv
module tkp_window
    import tkp_pkg::*;
#(
    parameter int unsigned NREG = DEF_NREG,
    parameter int unsigned RW   = DEF_RW
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             unlock,
    input  cyc_kind_e                        kind,
    output logic                             open_q,
    output logic [$clog2(NREG*RW)-1:0]       pos_q
);
    localparam int unsigned TOTAL = NREG * RW;
    localparam int unsigned PW    = $clog2(TOTAL);
    localparam logic [PW-1:0] LAST = PW'(TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            pos_q  <= '0;
        end else if (!open_q) begin
            pos_q <= '0;
            if (unlock) begin
                open_q <= 1'b1;
            end
        end else if (kind != CK_NONE) begin
            if (pos_q == LAST) begin
                open_q <= 1'b0;
                pos_q  <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tkp_shadow.sv
module tkp_shadow
    import tkp_pkg::*;
#(
    parameter int unsigned NREG = DEF_NREG,
    parameter int unsigned RW   = DEF_RW
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load,
    input  logic [NREG*RW-1:0]               live,
    input  logic [$clog2(NREG*RW)-1:0]       pos,
    output logic                             bit_o
);
    localparam int unsigned PW = $clog2(NREG * RW);
    localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned BW = (RW > 1) ? $clog2(RW) : 1;

    logic [RW-1:0] snap_q [NREG];
    logic [IW-1:0] ridx;
    logic [BW-1:0] bidx;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                snap_q[r] <= '0;
            end else if (load) begin
                snap_q[r] <= live[r*RW +: RW];
            end
        end
    end

    assign ridx  = IW'(reg_of(32'(pos), RW));
    assign bidx  = BW'(bit_of(32'(pos), RW));
    assign bit_o = snap_q[ridx][bidx];

    logic unused_pw;
    assign unused_pw = ^PW;

endmodule

// File: rtl/tkp_stage.sv
module tkp_stage
    import tkp_pkg::*;
#(
    parameter int unsigned NREG = DEF_NREG,
    parameter int unsigned RW   = DEF_RW
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        open_i,
    input  cyc_kind_e                                   kind,
    input  logic [$clog2(NREG*RW)-1:0]                  pos,
    input  logic                                        din,
    output logic                                        wr_stb,
    output logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0]  wr_idx,
    output logic [RW-1:0]                               wr_data
);
    localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned BW = (RW > 1) ? $clog2(RW) : 1;
    localparam logic [BW-1:0] TOP_BIT = BW'(RW - 1);

    logic [RW-1:0] stage_q;
    logic          clean_q;
    logic [IW-1:0] ridx;
    logic [BW-1:0] bidx;
    logic          counted;
    logic          is_wr;
    logic          clean_now;
    logic [RW-1:0] merged;

    assign ridx    = IW'(reg_of(32'(pos), RW));
    assign bidx    = BW'(bit_of(32'(pos), RW));
    assign counted = open_i && (kind != CK_NONE);
    assign is_wr   = (kind == CK_WRITE);

    always_comb begin
        clean_now = is_wr && ((bidx == '0) ? 1'b1 : clean_q);
        merged       = stage_q;
        merged[bidx] = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            clean_q <= 1'b0;
            wr_stb  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (counted) begin
                clean_q <= clean_now;
                if (is_wr) begin
                    stage_q[bidx] <= din;
                end
                if ((bidx == TOP_BIT) && clean_now) begin
                    wr_stb  <= 1'b1;
                    wr_idx  <= ridx;
                    wr_data <= merged;
                end
            end
        end
    end

endmodule

// File: rtl/serial_tkreg_port.sv
module serial_tkreg_port
    import tkp_pkg::*;
#(
    parameter int unsigned NREG = DEF_NREG,
    parameter int unsigned RW   = DEF_RW
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        unlock,
    input  logic                                        cyc_stb,
    input  logic                                        ce,
    input  logic                                        oe,
    input  logic                                        we,
    input  logic                                        dq0_i,
    input  logic [NREG*RW-1:0]                          live_regs,
    output logic                                        dq0_o,
    output logic                                        dq0_oe,
    output logic                                        mem_block,
    output logic                                        wr_stb,
    output logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0]  wr_idx,
    output logic [RW-1:0]                               wr_data
);
    localparam int unsigned PW = $clog2(NREG * RW);

    bus_cyc_t        bus;
    cyc_kind_e       kind;
    logic            open_q;
    logic [PW-1:0]   pos_q;
    logic            snap_bit;

    assign bus  = '{stb: cyc_stb, sel: ce, rd_en: oe, wr_en: we, din: dq0_i};
    assign kind = classify(bus);

    tkp_window #(.NREG(NREG), .RW(RW)) u_window (
        .clk    (clk),
        .rst    (rst),
        .unlock (unlock),
        .kind   (kind),
        .open_q (open_q),
        .pos_q  (pos_q)
    );

    tkp_shadow #(.NREG(NREG), .RW(RW)) u_shadow (
        .clk   (clk),
        .rst   (rst),
        .load  (unlock && !open_q),
        .live  (live_regs),
        .pos   (pos_q),
        .bit_o (snap_bit)
    );

    tkp_stage #(.NREG(NREG), .RW(RW)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .open_i  (open_q),
        .kind    (kind),
        .pos     (pos_q),
        .din     (bus.din),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    assign mem_block = open_q;
    assign dq0_o     = open_q && snap_bit;
    assign dq0_oe    = open_q && ce && bus.rd_en && !we;

endmodule

module tkp_chk #(
    parameter int unsigned NREG = 8,
    parameter int unsigned RW   = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          unlock,
    input logic                          cyc_stb,
    input logic                          ce,
    input logic                          we,
    input logic                          dq0_oe,
    input logic                          mem_block,
    input logic                          wr_stb,
    input logic [$clog2(NREG*RW)-1:0]    pos
);
    localparam int unsigned PW = $clog2(NREG * RW);
    localparam logic [PW-1:0] LAST = PW'(NREG * RW - 1);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!mem_block && !wr_stb));

    // R2
    a_r2_opens_at_zero: assert property (@(posedge clk) disable iff (rst)
        (!mem_block && unlock) |=> (mem_block && pos == '0));

    // R2, R9
    a_r9_idle_holds_pos: assert property (@(posedge clk) disable iff (rst)
        (mem_block && !(cyc_stb && ce)) |=> (mem_block && $stable(pos)));

    // R3
    a_r3_closes_after_last: assert property (@(posedge clk) disable iff (rst)
        (mem_block && pos == LAST && cyc_stb && ce) |=> !mem_block);

    // R7
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R7, R10
    a_r7_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_stb) |-> $past(cyc_stb && ce && we && mem_block));

    // R6, R10
    a_r10_no_drive_closed: assert property (@(posedge clk) disable iff (rst)
        !mem_block |-> !dq0_oe);

    // R6
    a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        we |-> !dq0_oe);

    logic unused_ok;
    assign unused_ok = ^{unlock};
endmodule

bind serial_tkreg_port tkp_chk #(.NREG(NREG), .RW(RW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .unlock    (unlock),
    .cyc_stb   (cyc_stb),
    .ce        (ce),
    .we        (we),
    .dq0_oe    (dq0_oe),
    .mem_block (mem_block),
    .wr_stb    (wr_stb),
    .pos       (pos_q)
);

// File: tb/tb_serial_tkreg_port.sv
`timescale 1ns/1ps
module tb_serial_tkreg_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unlock = 1'b0;
    logic        cyc_stb = 1'b0;
    logic        ce = 1'b0;
    logic        oe = 1'b0;
    logic        we = 1'b0;
    logic        dq0_i = 1'b0;
    logic [63:0] live_regs = '0;
    logic        dq0_o;
    logic        dq0_oe;
    logic        mem_block;
    logic        wr_stb;
    logic [2:0]  wr_idx;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_bad = 0;
    logic rb, ro;

    always #10 clk = ~clk;

    serial_tkreg_port dut (
        .clk(clk), .rst(rst), .unlock(unlock), .cyc_stb(cyc_stb),
        .ce(ce), .oe(oe), .we(we), .dq0_i(dq0_i), .live_regs(live_regs),
        .dq0_o(dq0_o), .dq0_oe(dq0_oe), .mem_block(mem_block),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [7:0] pat_a(input int r); return to_bcd((r * 13 + 7) % 60); endfunction
    function automatic logic [7:0] pat_b(input int r); return to_bcd((r * 29 + 11) % 100); endfunction
    function automatic logic [7:0] pat_w(input int r); return to_bcd((r * 17 + 3) % 100); endfunction
    function automatic logic [7:0] pat_e(input int r); return to_bcd((r * 7 + 41) % 100); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic c, input logic o, input logic w, input logic d);
        @(negedge clk);
        ce = c; oe = o; we = w; dq0_i = d; cyc_stb = 1'b1;
        #1;
        rb = dq0_o;
        ro = dq0_oe;
        @(negedge clk);
        cyc_stb = 1'b0; ce = 1'b0; oe = 1'b0; we = 1'b0; dq0_i = 1'b0;
    endtask

    task automatic pulse_unlock();
        @(negedge clk);
        unlock = 1'b1;
        @(negedge clk);
        unlock = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) live_regs[r*8 +: 8] = pat_a(r);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mem_block", 32'(mem_block), 0);
        chk("R1 dq0_oe", 32'(dq0_oe), 0);
        chk("R1 wr_stb", 32'(wr_stb), 0);

        // R10: cycles before unlock do nothing
        for (int i = 0; i < 8; i++) begin
            bus(1'b1, (i % 2) == 0, (i % 2) == 1, 1'b1);
            chk("R10 drive closed", 32'(ro), 0);
            chk("R10 strobe closed", 32'(wr_stb), 0);
            chk("R10 window closed", 32'(mem_block), 0);
        end

        // R2/R4/R5/R6/R9: full read sweep with live change and stray unlock
        pulse_unlock();
        chk("R2 window open", 32'(mem_block), 1);
        for (int k = 0; k < 64; k++) begin
            if (k == 20) begin
                for (int r = 0; r < 8; r++) live_regs[r*8 +: 8] = pat_b(r);
            end
            if (k == 30) begin
                pulse_unlock();
                chk("R2 stray unlock keeps window", 32'(mem_block), 1);
            end
            if (k % 5 == 2) begin
                bus(1'b0, 1'b1, 1'b0, 1'b0);
                chk("R9 ce low no drive", 32'(ro), 0);
            end
            if (k == 40) begin
                bus(1'b1, 1'b0, 1'b0, 1'b0);
                chk("R6 oe low no drive", 32'(ro), 0);
            end else begin
                bus(1'b1, 1'b1, 1'b0, 1'b0);
                chk("R6 read drives", 32'(ro), 1);
                chk($sformatf("R4 R5 read bit %0d", k), 32'(rb), 32'((pat_a(k / 8) >> (k % 8)) & 1));
            end
            chk("R3 window state", 32'(mem_block), (k == 63) ? 0 : 1);
        end

        // R7/R9: full write sweep
        pulse_unlock();
        for (int k = 0; k < 64; k++) begin
            if (k % 3 == 1) begin
                bus(1'b0, 1'b0, 1'b1, ~((pat_w(k / 8) >> (k % 8)) & 1'b1));
                chk("R9 ce low no strobe", 32'(wr_stb), 0);
            end
            bus(1'b1, 1'b1, 1'b1, (pat_w(k / 8) >> (k % 8)) & 1'b1);
            chk("R6 write no drive", 32'(ro), 0);
            chk($sformatf("R7 strobe at %0d", k), 32'(wr_stb), (k % 8 == 7) ? 1 : 0);
            if (k % 8 == 7) begin
                chk("R7 index", 32'(wr_idx), 32'(k / 8));
                chk("R7 data", 32'(wr_data), 32'(pat_w(k / 8)));
            end
            chk("R3 window state w", 32'(mem_block), (k == 63) ? 0 : 1);
        end
        bus(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R10 write after close", 32'(wr_stb), 0);

        // R8: mixed bytes never commit
        pulse_unlock();
        for (int k = 0; k < 64; k++) begin
            logic is_rd;
            is_rd = (k == 7) || (k == 8);
            if (is_rd) bus(1'b1, 1'b1, 1'b0, 1'b0);
            else bus(1'b1, 1'b0, 1'b1, (pat_e(k / 8) >> (k % 8)) & 1'b1);
            if (k % 8 == 7) begin
                if (k < 16) begin
                    chk($sformatf("R8 mixed reg %0d no strobe", k / 8), 32'(wr_stb), 0);
                end else begin
                    chk("R7 strobe after mixed", 32'(wr_stb), 1);
                    chk("R7 index after mixed", 32'(wr_idx), 32'(k / 8));
                    chk("R7 data after mixed", 32'(wr_data), 32'(pat_e(k / 8)));
                end
            end
        end
        chk("R3 closed after mixed", 32'(mem_block), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule